// File: doc/BRIEF.md
# Link Self-Test Loopback with Isolation Watchdog

This block sits between a serial link core (encoder, decoder and word buffers) and the physical link and front-panel pins of a crate module. When a control command selects self-test, the local transmit data and transmit request are turned back inside the module onto the receive data and receiver-ready inputs of the core. A remote operator can then write and read the module with no cable to a partner.

While self-test is active the module is cut off from the outside. The outgoing link lines are held low and external write requests are dropped. External read data returns zero, and the front-panel block-transfer port is closed. Only the crate dataway, which does not pass through this block, keeps working.

Self-test cannot be left on by accident. A millisecond watchdog ends it after a configurable number of ticks. Any command seen while it is running restarts the watchdog, so a long test stays alive as long as commands keep arriving. A dedicated command ends self-test at once.

All outputs are registered, and each one reflects the mode chosen at the same clock edge that sampled the command.

Top module: `selftest_loop`

## Requirements
- R1: A synchronous active-high reset turns self-test off, clears the watchdog count and drives every output low. With all inputs low, every output stays low on the first cycle after reset.
- R2: A command with `cmd_valid` high, `cmd_func` = 14 and `cmd_sub` = 0 turns self-test on. `isolate` reads 1 from the clock edge that samples that command.
- R3: While self-test is on, `core_rx_data` and `core_rx_rdy` take the values of `core_tx_data` and `core_tx_req` sampled at the previous edge. The link inputs have no effect on them.
- R4: While self-test is off, `core_rx_data` and `core_rx_rdy` follow `link_rx_data` and `link_rx_rdy`, and `link_tx_data` and `link_tx_req` follow `core_tx_data` and `core_tx_req`, each with one register stage.
- R5: While self-test is on, `link_tx_data`, `link_tx_req` and `ext_wr_pass` are 0 and `ext_rd_out` is all zeros, whatever the inputs are. When self-test is off, `ext_wr_pass` follows `ext_wr_req` and `ext_rd_out` follows `ext_rd_in`.
- R6: While self-test is on, `fp_bt_data_o`, `fp_bt_clk_o` and `fp_bt_ready` are 0. When it is off, the first two follow their inputs and `fp_bt_ready` follows `fp_bt_en`.
- R7: A command with `cmd_func` = 12 and `cmd_sub` = 0 turns self-test off at once, at the edge that samples it.
- R8: If no command arrives, self-test turns off at the edge that samples the TIMEOUT_MS-th `ms_tick` after it was turned on. It is still on after TIMEOUT_MS-1 ticks.
- R9: Any valid command sampled while self-test is on, of any function or subaddress, restarts the tick count from zero.
- R10: If a command and the expiring tick are sampled in the same cycle, the command wins. Self-test stays on and the count restarts.
- R11: Function 14 or 12 with a nonzero subaddress does not change the mode. When self-test is off it has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_func | input | 5 | Function code of the command |
| cmd_sub | input | 4 | Subaddress of the command |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| core_tx_data | input | 1 | Serial transmit data from the encoder |
| core_tx_req | input | 1 | Transmit request from the local core |
| link_rx_data | input | 1 | Serial data from the external link |
| link_rx_rdy | input | 1 | Receiver-ready from the external link |
| core_rx_data | output | 1 | Serial receive data to the decoder |
| core_rx_rdy | output | 1 | Receiver-ready to the local core |
| link_tx_data | output | 1 | Serial data to the external link |
| link_tx_req | output | 1 | Transmit request to the external link |
| ext_wr_req | input | 1 | Write request from an external port |
| ext_wr_pass | output | 1 | Write request passed to the buffers |
| ext_rd_in | input | DATA_W | Read data from the buffers for an external port |
| ext_rd_out | output | DATA_W | Read data presented to the external port |
| fp_bt_en | input | 1 | Front-panel block transfer enabled |
| fp_bt_data | input | 1 | Front-panel block-transfer data |
| fp_bt_clk | input | 1 | Front-panel block-transfer clock |
| fp_bt_data_o | output | 1 | Gated block-transfer data |
| fp_bt_clk_o | output | 1 | Gated block-transfer clock |
| fp_bt_ready | output | 1 | Front panel ready for block transfer |
| isolate | output | 1 | Self-test active, module isolated |

## Verification
Two watchdog events can fall in the same cycle: a restarting command and the tick that would end self-test. The bench provokes this on purpose. It enters self-test, sends TIMEOUT_MS-1 ticks, and then drives a non-loop command together with the last tick. It judges the outcome by `isolate` staying high and by a full new TIMEOUT_MS-tick window being needed before `isolate` falls. Random stimulus also lets commands, including ones with nonzero subaddresses, land on ticks by chance, and a bench model scores every cycle.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  localparam logic [4:0] FN_LOOP_ON  = 5'd14;
  localparam logic [4:0] FN_LOOP_OFF = 5'd12;
  localparam logic [3:0] SUB_CTRL    = 4'd0;

  typedef struct packed {
    logic set;
    logic clr;
    logic any;
  } loop_cmd_t;

endpackage

// File: rtl/loop_cmd_dec.sv
module loop_cmd_dec
  import selftest_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [4:0] cmd_func,
  input  logic [3:0] cmd_sub,
  output loop_cmd_t  cmd
);

  logic ctrl_sub;

  always_comb begin
    ctrl_sub = (cmd_sub == SUB_CTRL);
    cmd.any  = cmd_valid;
    cmd.set  = cmd_valid && ctrl_sub && (cmd_func == FN_LOOP_ON);
    cmd.clr  = cmd_valid && ctrl_sub && (cmd_func == FN_LOOP_OFF);
  end

endmodule

// File: rtl/loop_wdog.sv
module loop_wdog
  import selftest_pkg::*;
#(
  parameter int TIMEOUT_MS = 200
) (
  input  logic      clk,
  input  logic      rst,
  input  loop_cmd_t cmd,
  input  logic      ms_tick,
  output logic      loop_next,
  output logic      loop_q
);

  localparam int              CNT_W = $clog2(TIMEOUT_MS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_MS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_next;

  always_comb begin
    loop_next = loop_q;
    cnt_next  = cnt_q;
    if (cmd.clr) begin
      loop_next = 1'b0;
      cnt_next  = '0;
    end else if (cmd.set) begin
      loop_next = 1'b1;
      cnt_next  = '0;
    end else if (loop_q && cmd.any) begin
      cnt_next  = '0;
    end else if (loop_q && ms_tick) begin
      if (cnt_q == LAST) begin
        loop_next = 1'b0;
        cnt_next  = '0;
      end else begin
        cnt_next  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      loop_q <= loop_next;
      cnt_q  <= cnt_next;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R1
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_q |-> cnt_q == '0);

  // R2
  set_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.set |=> loop_q);

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.clr |=> !loop_q);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_q && cmd.any && !cmd.clr) |=> (loop_q && cnt_q == '0));

  // R8
  expire_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_q && ms_tick && !cmd.any && cnt_q == LAST) |=> !loop_q);

endmodule

// File: rtl/link_iso_mux.sv
module link_iso_mux #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_next,
  input  logic              core_tx_data,
  input  logic              core_tx_req,
  input  logic              link_rx_data,
  input  logic              link_rx_rdy,
  input  logic              ext_wr_req,
  input  logic [DATA_W-1:0] ext_rd_in,
  input  logic              fp_bt_en,
  input  logic              fp_bt_data,
  input  logic              fp_bt_clk,
  output logic              core_rx_data,
  output logic              core_rx_rdy,
  output logic              link_tx_data,
  output logic              link_tx_req,
  output logic              ext_wr_pass,
  output logic [DATA_W-1:0] ext_rd_out,
  output logic              fp_bt_data_o,
  output logic              fp_bt_clk_o,
  output logic              fp_bt_ready
);

  logic open_n;

  always_comb open_n = ~loop_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rx_data <= 1'b0;
      core_rx_rdy  <= 1'b0;
      link_tx_data <= 1'b0;
      link_tx_req  <= 1'b0;
      ext_wr_pass  <= 1'b0;
      ext_rd_out   <= '0;
      fp_bt_data_o <= 1'b0;
      fp_bt_clk_o  <= 1'b0;
      fp_bt_ready  <= 1'b0;
    end else begin
      core_rx_data <= loop_next ? core_tx_data : link_rx_data;
      core_rx_rdy  <= loop_next ? core_tx_req  : link_rx_rdy;
      link_tx_data <= open_n & core_tx_data;
      link_tx_req  <= open_n & core_tx_req;
      ext_wr_pass  <= open_n & ext_wr_req;
      ext_rd_out   <= ext_rd_in & {DATA_W{open_n}};
      fp_bt_data_o <= open_n & fp_bt_data;
      fp_bt_clk_o  <= open_n & fp_bt_clk;
      fp_bt_ready  <= open_n & fp_bt_en;
    end
  end

endmodule

// File: rtl/selftest_loop.sv
module selftest_loop
  import selftest_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int TIMEOUT_MS = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [4:0]        cmd_func,
  input  logic [3:0]        cmd_sub,
  input  logic              ms_tick,
  input  logic              core_tx_data,
  input  logic              core_tx_req,
  input  logic              link_rx_data,
  input  logic              link_rx_rdy,
  output logic              core_rx_data,
  output logic              core_rx_rdy,
  output logic              link_tx_data,
  output logic              link_tx_req,
  input  logic              ext_wr_req,
  output logic              ext_wr_pass,
  input  logic [DATA_W-1:0] ext_rd_in,
  output logic [DATA_W-1:0] ext_rd_out,
  input  logic              fp_bt_en,
  input  logic              fp_bt_data,
  input  logic              fp_bt_clk,
  output logic              fp_bt_data_o,
  output logic              fp_bt_clk_o,
  output logic              fp_bt_ready,
  output logic              isolate
);

  loop_cmd_t cmd;
  logic      loop_next;

  loop_cmd_dec u_dec (
    .cmd_valid (cmd_valid),
    .cmd_func  (cmd_func),
    .cmd_sub   (cmd_sub),
    .cmd       (cmd)
  );

  loop_wdog #(.TIMEOUT_MS(TIMEOUT_MS)) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .ms_tick   (ms_tick),
    .loop_next (loop_next),
    .loop_q    (isolate)
  );

  link_iso_mux #(.DATA_W(DATA_W)) u_mux (
    .clk          (clk),
    .rst          (rst),
    .loop_next    (loop_next),
    .core_tx_data (core_tx_data),
    .core_tx_req  (core_tx_req),
    .link_rx_data (link_rx_data),
    .link_rx_rdy  (link_rx_rdy),
    .ext_wr_req   (ext_wr_req),
    .ext_rd_in    (ext_rd_in),
    .fp_bt_en     (fp_bt_en),
    .fp_bt_data   (fp_bt_data),
    .fp_bt_clk    (fp_bt_clk),
    .core_rx_data (core_rx_data),
    .core_rx_rdy  (core_rx_rdy),
    .link_tx_data (link_tx_data),
    .link_tx_req  (link_tx_req),
    .ext_wr_pass  (ext_wr_pass),
    .ext_rd_out   (ext_rd_out),
    .fp_bt_data_o (fp_bt_data_o),
    .fp_bt_clk_o  (fp_bt_clk_o),
    .fp_bt_ready  (fp_bt_ready)
  );

  // R5
  iso_link_chk: assert property (@(posedge clk) disable iff (rst)
    isolate |-> (!link_tx_data && !link_tx_req && !ext_wr_pass && ext_rd_out == '0));

  // R6
  iso_fp_chk: assert property (@(posedge clk) disable iff (rst)
    isolate |-> (!fp_bt_data_o && !fp_bt_clk_o && !fp_bt_ready));

  // R11
  sub_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!isolate && cmd_valid && cmd_sub != 4'd0) |=> !isolate);

endmodule

// File: tb/sim_selftest_loop.sv
module sim_selftest_loop;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TMO = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0;
  logic [4:0] cmd_func = 0;
  logic [3:0] cmd_sub = 0;
  logic ms_tick = 0;
  logic core_tx_data = 0, core_tx_req = 0, link_rx_data = 0, link_rx_rdy = 0;
  logic core_rx_data, core_rx_rdy, link_tx_data, link_tx_req;
  logic ext_wr_req = 0, ext_wr_pass;
  logic [DW-1:0] ext_rd_in = 0, ext_rd_out;
  logic fp_bt_en = 0, fp_bt_data = 0, fp_bt_clk = 0;
  logic fp_bt_data_o, fp_bt_clk_o, fp_bt_ready, isolate;

  int checks = 0;
  int fails = 0;
  logic m_loop = 0;
  int   m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_loop #(.DATA_W(DW), .TIMEOUT_MS(TMO)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func), .cmd_sub(cmd_sub),
    .ms_tick(ms_tick), .core_tx_data(core_tx_data), .core_tx_req(core_tx_req),
    .link_rx_data(link_rx_data), .link_rx_rdy(link_rx_rdy),
    .core_rx_data(core_rx_data), .core_rx_rdy(core_rx_rdy),
    .link_tx_data(link_tx_data), .link_tx_req(link_tx_req),
    .ext_wr_req(ext_wr_req), .ext_wr_pass(ext_wr_pass),
    .ext_rd_in(ext_rd_in), .ext_rd_out(ext_rd_out),
    .fp_bt_en(fp_bt_en), .fp_bt_data(fp_bt_data), .fp_bt_clk(fp_bt_clk),
    .fp_bt_data_o(fp_bt_data_o), .fp_bt_clk_o(fp_bt_clk_o),
    .fp_bt_ready(fp_bt_ready), .isolate(isolate)
  );

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Mode model from the requirements (R2, R7, R8, R9, R10, R11)
  function automatic void model_step(input logic v, input logic [4:0] f,
                                     input logic [3:0] s, input logic t);
    if (v && f == 5'd12 && s == 4'd0) begin m_loop = 0; m_cnt = 0; end
    else if (v && f == 5'd14 && s == 4'd0) begin m_loop = 1; m_cnt = 0; end
    else if (m_loop && v) m_cnt = 0;
    else if (m_loop && t) begin
      if (m_cnt == TMO - 1) begin m_loop = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endfunction

  // Drive one cycle of stimulus, then check all outputs after the edge.
  task automatic step(input string iso_tag, input logic v, input logic [4:0] f,
                      input logic [3:0] s, input logic t);
    logic [DW-1:0] rd;
    logic txd, txr, rxd, rxr, wr, en, fd, fc;
    @(negedge clk);
    cmd_valid = v; cmd_func = f; cmd_sub = s; ms_tick = t;
    txd = 1'($urandom); txr = 1'($urandom); rxd = 1'($urandom); rxr = 1'($urandom);
    wr = 1'($urandom); en = 1'($urandom); fd = 1'($urandom); fc = 1'($urandom);
    rd = DW'($urandom);
    core_tx_data = txd; core_tx_req = txr; link_rx_data = rxd; link_rx_rdy = rxr;
    ext_wr_req = wr; ext_rd_in = rd; fp_bt_en = en; fp_bt_data = fd; fp_bt_clk = fc;
    model_step(v, f, s, t);
    @(posedge clk);
    #1;
    chk(iso_tag, "isolate", DW'(isolate), DW'(m_loop));
    if (m_loop) begin
      chk("R3", "core_rx_data", DW'(core_rx_data), DW'(txd));
      chk("R3", "core_rx_rdy",  DW'(core_rx_rdy),  DW'(txr));
      chk("R5", "link_tx", DW'({link_tx_data, link_tx_req}), '0);
      chk("R5", "ext_wr_pass", DW'(ext_wr_pass), '0);
      chk("R5", "ext_rd_out", ext_rd_out, '0);
      chk("R6", "fp outs", DW'({fp_bt_data_o, fp_bt_clk_o, fp_bt_ready}), '0);
    end else begin
      chk("R4", "core_rx", DW'({core_rx_data, core_rx_rdy}), DW'({rxd, rxr}));
      chk("R4", "link_tx", DW'({link_tx_data, link_tx_req}), DW'({txd, txr}));
      chk("R5", "ext_wr_pass", DW'(ext_wr_pass), DW'(wr));
      chk("R5", "ext_rd_out", ext_rd_out, rd);
      chk("R6", "fp outs", DW'({fp_bt_data_o, fp_bt_clk_o, fp_bt_ready}), DW'({fd, fc, en}));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state with quiet inputs
    chk("R1", "isolate", DW'(isolate), '0);
    chk("R1", "outs", DW'({core_rx_data, core_rx_rdy, link_tx_data, link_tx_req,
        ext_wr_pass, fp_bt_data_o, fp_bt_clk_o, fp_bt_ready}), '0);
    chk("R1", "ext_rd_out", ext_rd_out, '0);

    // R11: F14/F12 with nonzero subaddress while off
    step("R11", 1, 5'd14, 4'd1, 0);
    step("R11", 1, 5'd12, 4'd3, 1);
    // R2: enter, R3 loop data over several cycles
    step("R2", 1, 5'd14, 4'd0, 0);
    for (int i = 0; i < 4; i++) step("R3", 0, 0, 0, 0);
    // R11: F12 with nonzero subaddress keeps loop
    step("R11", 1, 5'd12, 4'd2, 0);
    // R7: immediate exit
    step("R7", 1, 5'd12, 4'd0, 0);

    // R8: timeout window
    step("R2", 1, 5'd14, 4'd0, 0);
    for (int i = 0; i < TMO - 1; i++) step("R8", 0, 0, 0, 1);
    chk("R8", "still on before last tick", DW'(isolate), 1);
    step("R8", 0, 0, 0, 1);
    chk("R8", "off after last tick", DW'(isolate), 0);

    // R9: restart by unrelated command
    step("R2", 1, 5'd14, 4'd0, 0);
    for (int i = 0; i < TMO - 1; i++) step("R9", 0, 0, 0, 1);
    step("R9", 1, 5'd6, 4'd0, 0);
    for (int i = 0; i < TMO - 1; i++) step("R9", 0, 0, 0, 1);
    chk("R9", "on after restart", DW'(isolate), 1);
    step("R9", 0, 0, 0, 1);
    chk("R9", "off after full new window", DW'(isolate), 0);

    // R10: command and expiring tick in same cycle
    step("R2", 1, 5'd14, 4'd0, 0);
    for (int i = 0; i < TMO - 1; i++) step("R10", 0, 0, 0, 1);
    step("R10", 1, 5'd0, 4'd5, 1);
    chk("R10", "command beats tick", DW'(isolate), 1);
    for (int i = 0; i < TMO - 1; i++) step("R10", 0, 0, 0, 1);
    step("R10", 0, 0, 0, 1);
    chk("R10", "expires after new window", DW'(isolate), 0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic v, t;
      logic [4:0] f;
      logic [3:0] s;
      int sel;
      v = ($urandom % 6) == 0;
      t = ($urandom % 2) == 0;
      sel = $urandom % 4;
      f = (sel == 0) ? 5'd14 : (sel == 1) ? 5'd12 : 5'($urandom);
      s = (($urandom % 3) != 0) ? 4'd0 : 4'($urandom);
      step("R9", v, f, s, t);
    end

    // R1: synchronous reset while looped
    step("R2", 1, 5'd14, 4'd0, 0);
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 0;
    @(posedge clk);
    #1;
    chk("R1", "isolate cleared by reset", DW'(isolate), 0);
    @(negedge clk);
    rst = 1'b0;
    m_loop = 0; m_cnt = 0;
    step("R1", 0, 0, 0, 1);

    finish_run();
  end

endmodule